// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers and the saved-status registers for a processor core that has several operating modes. The core presents a 5-bit mode code together with register indices 0 to 15. The block maps each index onto its physical storage for that mode. Some registers are shared by every mode. Some are private to the fast-interrupt mode. Each exception mode has its own stack pointer (index 13) and link register (index 14).

There are two combinational read ports and one write port for general registers. The write port commits on the rising clock edge. A separate port reads and writes the saved-status register of the current mode. Index 15 is the program counter, which lives outside the block: reads of it return the `pc_in` input. Changing the mode code never alters stored contents; it only changes which storage is visible.

Physical storage is 30 general registers and 5 saved-status registers. The program counter and the current status word, held elsewhere, bring the total to 37. None of the ports carries a stream, so there is no valid/ready handshake and no back-pressure. Every port is sampled or driven each cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset is released, every index 0–14 reads zero in every mode, and the saved-status port reads zero.
- R2: Indices 0–7 name the same storage in every mode. A value written in any mode is read back in all modes.
- R3: Indices 8–12 are shared by all modes except fast interrupt (code 5'b10001), which has its own private copies. A write in either group leaves the other group unchanged.
- R4: Indices 13 and 14 are private to each exception mode: fast interrupt 5'b10001, IRQ 5'b10010, supervisor 5'b10011, abort 5'b10111 and undefined 5'b11011. User (5'b10000) and system (5'b11111) share one copy.
- R5: Any mode code not listed in R4 selects the same storage as user mode.
- R6: A read of index 15 on either port returns `pc_in`. A write to index 15 changes no stored register.
- R7: When a read port and the write port address the same register in the same cycle, the read returns `wr_data` in that cycle.
- R8: Each of the five exception modes has its own saved-status register. A write through the status port is read back in that mode, and it survives changes to other modes. A read in the same cycle as a write returns the new value.
- R9: In user mode, system mode or an unrecognised mode, the status port reads zero and status writes are discarded.
- R10: The two read ports are independent. Each returns the register named by its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all storage |
| mode | input | 5 | Current mode code |
| pc_in | input | DATA_W | Program counter value returned for index 15 |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | DATA_W | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | DATA_W | General register write data |
| sps_wr_en | input | 1 | Saved-status write enable for the current mode |
| sps_wr_data | input | DATA_W | Saved-status write data |
| sps_rd_data | output | DATA_W | Saved-status value of the current mode |

## Verification
The hardest case to reach is a state in which every bank holds a different value at the same index. Only then can a wrong mapping show up, for example fast-interrupt R10 landing on the shared R10. The stimulus reaches it by writing every index, and the status register, in each of the eight mode codes in turn, one of them unrecognised, with values that encode both the mode and the index. It then reads every index in every mode. The expected value at each place is the last write made in any mode that shares that storage. Same-cycle bypass and writes to index 15 are then driven on top of this fully populated state.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  typedef enum logic [4:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int IDX_W      = 4;
  localparam int NUM_SHARED = 15;                 // R0..R14 of user/system
  localparam int FIQ_PRIV   = 7;                  // R8..R14 of fast interrupt
  localparam int NUM_EXC4   = 4;                  // irq, svc, abt, und
  localparam int NUM_PHYS   = NUM_SHARED + FIQ_PRIV + 2 * NUM_EXC4;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
  localparam int NUM_SPS    = 5;
  localparam int SPS_W      = $clog2(NUM_SPS);

  function automatic logic is_exc_mode(logic [4:0] m);
    return (m == MD_FIQ) || (m == MD_IRQ) || (m == MD_SVC) ||
           (m == MD_ABT) || (m == MD_UND);
  endfunction

endpackage

// File: rtl/bank_decode.sv
module bank_decode
  import bankrf_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank
);
  always_comb begin
    unique case (mode)
      MD_FIQ:  bank = BK_FIQ;
      MD_IRQ:  bank = BK_IRQ;
      MD_SVC:  bank = BK_SVC;
      MD_ABT:  bank = BK_ABT;
      MD_UND:  bank = BK_UND;
      default: bank = BK_USR;
    endcase
  end
endmodule

// File: rtl/phys_map.sv
module phys_map
  import bankrf_pkg::*;
(
  input  bank_e              bank,
  input  logic [IDX_W-1:0]   idx,
  output logic [PHYS_W-1:0]  phys,
  output logic               is_pc
);
  localparam int FIQ_BASE = NUM_SHARED;        // holds fiq R8..R14
  localparam int EXC_BASE = FIQ_BASE + FIQ_PRIV; // pairs of R13/R14

  logic [PHYS_W-1:0] sp_base;

  always_comb begin
    unique case (bank)
      BK_FIQ:  sp_base = PHYS_W'(FIQ_BASE + 5);
      BK_IRQ:  sp_base = PHYS_W'(EXC_BASE + 0);
      BK_SVC:  sp_base = PHYS_W'(EXC_BASE + 2);
      BK_ABT:  sp_base = PHYS_W'(EXC_BASE + 4);
      BK_UND:  sp_base = PHYS_W'(EXC_BASE + 6);
      default: sp_base = PHYS_W'(13);
    endcase
  end

  always_comb begin
    is_pc = (idx == 4'hF);
    if (idx < 4'd8) begin
      phys = PHYS_W'(idx);
    end else if (idx < 4'd13) begin
      phys = (bank == BK_FIQ) ? PHYS_W'(FIQ_BASE) + PHYS_W'(idx - 4'd8)
                              : PHYS_W'(idx);
    end else if (idx == 4'd13) begin
      phys = sp_base;
    end else begin
      phys = sp_base + PHYS_W'(1);  // idx 14; idx 15 handled by is_pc
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PHYS_W-1:0]  wr_phys,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [PHYS_W-1:0]  rd_phys [NUM_RD],
  output logic [DATA_W-1:0]  rd_data [NUM_RD]
);
  logic [DATA_W-1:0] regs [NUM_PHYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PHYS; k++) regs[k] <= '0;
    end else if (wr_en) begin
      regs[wr_phys] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_data[g] = (wr_en && (wr_phys == rd_phys[g])) ? wr_data
                                                           : regs[rd_phys[g]];
  end
endmodule

// File: rtl/sps_store.sv
module sps_store
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sps [NUM_SPS];
  logic              has_sps;
  logic [SPS_W-1:0]  slot;

  assign has_sps = (bank != BK_USR);
  assign slot    = SPS_W'(bank - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SPS; k++) sps[k] <= '0;
    end else if (wr_en && has_sps) begin
      sps[slot] <= wr_data;
    end
  end

  always_comb begin
    if (!has_sps)    rd_data = '0;
    else if (wr_en)  rd_data = wr_data;
    else             rd_data = sps[slot];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sps_wr_en,
  input  logic [DATA_W-1:0] sps_wr_data,
  output logic [DATA_W-1:0] sps_rd_data
);
  localparam int NUM_RD = 2;

  bank_e             bank;
  logic [IDX_W-1:0]  rd_idx     [NUM_RD];
  logic [PHYS_W-1:0] rd_phys    [NUM_RD];
  logic              rd_is_pc   [NUM_RD];
  logic [DATA_W-1:0] rd_store   [NUM_RD];
  logic [DATA_W-1:0] rd_out     [NUM_RD];
  logic [PHYS_W-1:0] wr_phys;
  logic              wr_is_pc;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  bank_decode u_dec (.mode(mode), .bank(bank));

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rport
    phys_map u_map (
      .bank (bank),
      .idx  (rd_idx[g]),
      .phys (rd_phys[g]),
      .is_pc(rd_is_pc[g])
    );
    assign rd_out[g] = rd_is_pc[g] ? pc_in : rd_store[g];
  end

  phys_map u_wmap (
    .bank (bank),
    .idx  (wr_idx),
    .phys (wr_phys),
    .is_pc(wr_is_pc)
  );

  gpr_store #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_gpr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en && !wr_is_pc),
    .wr_phys(wr_phys),
    .wr_data(wr_data),
    .rd_phys(rd_phys),
    .rd_data(rd_store)
  );

  sps_store #(.DATA_W(DATA_W)) u_sps (
    .clk    (clk),
    .rst_n  (rst_n),
    .bank   (bank),
    .wr_en  (sps_wr_en),
    .wr_data(sps_wr_data),
    .rd_data(sps_rd_data)
  );

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];
endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode,
  input logic [DATA_W-1:0] pc_in,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sps_wr_en,
  input logic [DATA_W-1:0] sps_wr_data,
  input logic [DATA_W-1:0] sps_rd_data
);
  p_pc_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'hF) |-> (rd_a_data == pc_in));

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 4'hF && rd_b_idx == wr_idx) |-> (rd_b_data == wr_data));

  p_sps_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_exc_mode(mode)) |-> (sps_rd_data == '0));

  p_shared_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && ($past(wr_idx) < 4'd8) && (rd_a_idx == $past(wr_idx)) && !wr_en)
      |-> (rd_a_data == $past(wr_data)));

  p_sps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sps_wr_en) && is_exc_mode($past(mode)) && (mode == $past(mode)) && !sps_wr_en)
      |-> (sps_rd_data == $past(sps_wr_data)));
endmodule

bind banked_regfile bankrf_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    mode = 5'b10000;
  logic [DW-1:0] pc_in = '0;
  logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, sps_rd_data;
  logic          wr_en = 1'b0, sps_wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0, sps_wr_data = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  banked_regfile #(.DATA_W(DW)) u0 (.*);

  logic [4:0] codes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b11111, 5'b00101};
  logic [DW-1:0] model [600];
  logic [DW-1:0] sps_model [6];

  // Bank number from the requirements: 0 user/system/unknown, 1..5 exception modes
  function automatic int bank_of(logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  // Storage class key: identical keys mean shared storage (R2, R3, R4, R5)
  function automatic int key_of(logic [4:0] m, int i);
    int b = bank_of(m);
    if (i < 8)  return i;
    if (i < 13) return (b == 1) ? 100 + i : i;
    return b * 100 + i;
  endfunction

  function automatic logic [DW-1:0] val_of(int slot, int i, int salt);
    return {8'hC0 + 8'(slot), 8'(i), 16'((slot * 16 + i) ^ salt)};
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%b act=%h exp=%h", req, mode, act, exp);
    end
  endtask

  task automatic write_reg(logic [4:0] m, int i, logic [DW-1:0] v);
    @(negedge clk);
    mode = m; wr_en = 1'b1; wr_idx = 4'(i); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_sps(logic [4:0] m, logic [DW-1:0] v);
    @(negedge clk);
    mode = m; sps_wr_en = 1'b1; sps_wr_data = v;
    @(negedge clk);
    sps_wr_en = 1'b0;
  endtask

  task automatic read_pair(logic [4:0] m, int ia, int ib, string req);
    @(negedge clk);
    mode = m; rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
    #1;
    check(req, rd_a_data, (ia == 15) ? pc_in : model[key_of(m, ia)]);
    check(req, rd_b_data, (ib == 15) ? pc_in : model[key_of(m, ib)]);
  endtask

  task automatic sweep_all(string req);
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 15; i++) read_pair(codes[s], i, 14 - i, req);
      #1 check("R8/R9 sps", sps_rd_data, sps_model[bank_of(codes[s])]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 600; k++) model[k] = '0;
    for (int k = 0; k < 6; k++) sps_model[k] = '0;
    pc_in = 32'h0000_8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything clear after reset
    sweep_all("R1 reset");

    // Populate every bank in turn (R2 R3 R4 R5 R8)
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 15; i++) begin
        write_reg(codes[s], i, val_of(s, i, 16'h5A5A));
        model[key_of(codes[s], i)] = val_of(s, i, 16'h5A5A);
      end
      write_sps(codes[s], val_of(s, 15, 16'h3C3C));
      if (bank_of(codes[s]) != 0) sps_model[bank_of(codes[s])] = val_of(s, 15, 16'h3C3C);
      else sps_model[0] = '0; // R9: writes discarded
    end
    sweep_all("R2/R3/R4/R5/R10 banking");

    // Second pass in reverse order to flip which mode wrote last
    for (int s = 7; s >= 0; s--) begin
      for (int i = 8; i < 15; i++) begin
        write_reg(codes[s], i, val_of(s, i, 16'h1234));
        model[key_of(codes[s], i)] = val_of(s, i, 16'h1234);
      end
    end
    sweep_all("R3/R4 reverse pass");

    // R6: index 15 reads pc_in on both ports; writes to 15 discarded
    pc_in = 32'hDEAD_BEE0;
    read_pair(5'b10011, 15, 15, "R6 pc read");
    write_reg(5'b10011, 15, 32'hFFFF_FFFF);
    pc_in = 32'h0000_0124;
    sweep_all("R6 write to 15 ignored");

    // R7: same-cycle bypass on both ports, then R3 isolation
    @(negedge clk);
    mode = 5'b10001; wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'hA5A5_0009;
    rd_a_idx = 4'd9; rd_b_idx = 4'd9;
    #1;
    check("R7 bypass port A", rd_a_data, 32'hA5A5_0009);
    check("R7 bypass port B", rd_b_data, 32'hA5A5_0009);
    model[key_of(5'b10001, 9)] = 32'hA5A5_0009;
    @(negedge clk);
    wr_en = 1'b0;
    read_pair(5'b10000, 9, 9, "R3 user R9 untouched by fiq write");
    read_pair(5'b10001, 9, 0, "R7 fiq R9 committed");

    // R8: status bypass in the write cycle, and R9 user writes discarded
    @(negedge clk);
    mode = 5'b10010; sps_wr_en = 1'b1; sps_wr_data = 32'h600D_0012;
    #1 check("R8 sps bypass", sps_rd_data, 32'h600D_0012);
    sps_model[2] = 32'h600D_0012;
    @(negedge clk);
    sps_wr_en = 1'b0;
    write_sps(5'b10000, 32'hBAD0_BAD0);
    write_sps(5'b11111, 32'hBAD1_BAD1);
    sweep_all("R8/R9 after status writes");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule